// File: doc/BRIEF.md
# TLB Entry-Select and Next-Victim Controller

This block is the replacement-control slice of a two-level MMU. It holds one control register through which privileged software picks the translation array that a TLB write goes to, either a 4-way set-associative array of 128 sets or a 16-entry fully associative array. The same register also picks the way or entry inside that array. Next to the register the block keeps a round-robin victim pointer for every set of the set-associative array.

Hardware events change the register without any software write. On a miss exception or a search that misses, the register receives the victim chosen for the indexed set and that victim's successor. On a search hit it receives the way that hit. On an entry read it receives the stored victim. A write-entry command saves the register's next-victim value into the pointer of the indexed set. The set index is always the low seven bits of the effective page number. The entry-select field is read as a way number or as a full entry number, depending on which array is selected.

Top module: `tlb_victim_ctl`

## Requirements
- R1: After reset the register reads as zero, all outputs are zero and every set's victim pointer is zero, so a miss in any set then loads entry-select 0 and next-victim 1.
- R2: A register write while the supervisor input is high loads the array bit from bit 0, the 4-bit entry-select field from bits 11:8 and the 2-bit next-victim field from bits 21:20. Every other bit reads back as zero.
- R3: A register write while the supervisor input is low leaves the register unchanged.
- R4: With the array bit at 0 the entry output carries only the low two entry-select bits, and its upper two bits are zero. With the array bit at 1 the entry output carries all four bits.
- R5: The set index output equals the low seven bits of the effective page number.
- R6: A write-entry command with the array bit at 0 stores the next-victim field into the pointer of the indexed set. With the array bit at 1 it leaves every pointer unchanged.
- R7: A miss exception loads entry-select with the indexed set's pointer P and next-victim with (P+1) mod 4. The array bit is unchanged.
- R8: A search that misses updates the register in the same way as R7.
- R9: A search hit loads entry-select with the hit way and next-victim with the indexed set's pointer.
- R10: A read-entry command loads next-victim with the indexed set's pointer and leaves entry-select and the array bit unchanged.
- R11: When events coincide, only the one with the highest priority takes effect. The order from highest to lowest is miss exception, search, read-entry, software register write.
- R12: Register updates appear one clock after the event. Each set's pointer is independent of the pointers of the other sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sup_i | input | 1 | Supervisor mode; enables software writes |
| reg_wr_i | input | 1 | Software register write strobe |
| reg_wdata_i | input | 32 | Software write data |
| reg_rdata_o | output | 32 | Register readback |
| epn_i | input | 20 | Effective page number |
| wr_entry_i | input | 1 | Write-entry command |
| rd_entry_i | input | 1 | Read-entry command |
| srch_i | input | 1 | Search result valid |
| srch_hit_i | input | 1 | Search hit (1) or miss (0) |
| srch_way_i | input | 2 | Way that hit |
| miss_i | input | 1 | Miss exception event |
| arr_sel_o | output | 1 | Selected array (0 set-associative, 1 fully associative) |
| entry_sel_o | output | 4 | Selected way or entry |
| set_idx_o | output | 7 | Set index |
| nv_o | output | 2 | Next-victim value |

## Verification
A set's pointer cannot be read directly. A corrupted or misaddressed pointer therefore stays hidden until a later miss, search or read-entry on that same set, and the error then appears one clock later in the entry-select or next-victim field. The bench therefore stores a pointer in one set, then reads it back and triggers misses on that set and on a neighbouring set. A wrong priority or a wrong wrap only shows when two events coincide or when the pointer is 3, so both cases are exercised on purpose.

// File: rtl/tvc_pkg.sv
package tvc_pkg;
   localparam int REG_W    = 32;
   localparam int ARR_BIT  = 0;
   localparam int ESEL_LSB = 8;
   localparam int NV_LSB   = 20;
endpackage

// File: rtl/tvc_victim_store.sv
module tvc_victim_store #(
   parameter int SET_W       = 7,
   parameter int NV_W        = 2,
   parameter bit RESET_STORE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] rd_set_i,
   input  logic             wr_en_i,
   input  logic [SET_W-1:0] wr_set_i,
   input  logic [NV_W-1:0]  wr_val_i,
   output logic [NV_W-1:0]  rd_val_o
);
   localparam int NSETS = 1 << SET_W;

   logic [NSETS*NV_W-1:0] flat;

   for (genvar g = 0; g < NSETS; g++) begin : g_set
      logic [NV_W-1:0] ptr_q;
      logic            hit;
      assign hit = wr_en_i && (wr_set_i == SET_W'(g));
      if (RESET_STORE) begin : g_rst
         always_ff @(posedge clk) begin
            if (!rst_n)   ptr_q <= '0;
            else if (hit) ptr_q <= wr_val_i;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (hit) ptr_q <= wr_val_i;
         end
      end
      assign flat[g*NV_W +: NV_W] = ptr_q;
   end

   assign rd_val_o = flat[rd_set_i*NV_W +: NV_W];
endmodule

// File: rtl/tvc_ctl_reg.sv
module tvc_ctl_reg
   import tvc_pkg::*;
#(
   parameter int ESEL_W = 4,
   parameter int WAY_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sup_i,
   input  logic              sw_wr_i,
   input  logic [REG_W-1:0]  sw_wdata_i,
   input  logic              miss_i,
   input  logic              srch_i,
   input  logic              srch_hit_i,
   input  logic [WAY_W-1:0]  srch_way_i,
   input  logic              rd_entry_i,
   input  logic [WAY_W-1:0]  vict_i,
   output logic              arr_q,
   output logic [ESEL_W-1:0] esel_q,
   output logic [WAY_W-1:0]  nv_q,
   output logic [REG_W-1:0]  rdata_o
);
   logic              arr_d;
   logic [ESEL_W-1:0] esel_d;
   logic [WAY_W-1:0]  nv_d;
   logic [WAY_W-1:0]  vict_next;
   logic              take_miss;

   assign vict_next = vict_i + WAY_W'(1);
   assign take_miss = miss_i || (srch_i && !srch_hit_i);

   always_comb begin
      arr_d  = arr_q;
      esel_d = esel_q;
      nv_d   = nv_q;
      if (take_miss) begin
         esel_d = ESEL_W'(vict_i);
         nv_d   = vict_next;
      end else if (srch_i) begin
         esel_d = ESEL_W'(srch_way_i);
         nv_d   = vict_i;
      end else if (rd_entry_i) begin
         nv_d   = vict_i;
      end else if (sw_wr_i && sup_i) begin
         arr_d  = sw_wdata_i[ARR_BIT];
         esel_d = sw_wdata_i[ESEL_LSB +: ESEL_W];
         nv_d   = sw_wdata_i[NV_LSB +: WAY_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arr_q  <= 1'b0;
         esel_q <= '0;
         nv_q   <= '0;
      end else begin
         arr_q  <= arr_d;
         esel_q <= esel_d;
         nv_q   <= nv_d;
      end
   end

   always_comb begin
      rdata_o                       = '0;
      rdata_o[ARR_BIT]              = arr_q;
      rdata_o[ESEL_LSB +: ESEL_W]   = esel_q;
      rdata_o[NV_LSB +: WAY_W]      = nv_q;
   end

   p_miss_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      miss_i |=> (esel_q == ESEL_W'($past(vict_i))) &&
                 (nv_q == WAY_W'($past(vict_i) + WAY_W'(1))) && $stable(arr_q));

   p_hit_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (srch_i && srch_hit_i && !miss_i) |=>
         (esel_q == ESEL_W'($past(srch_way_i))) && (nv_q == $past(vict_i)));

   p_read_only_nv_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_entry_i && !miss_i && !srch_i) |=>
         $stable(esel_q) && $stable(arr_q) && (nv_q == $past(vict_i)));

   p_user_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr_i && !sup_i && !miss_i && !srch_i && !rd_entry_i) |=> $stable(rdata_o));
endmodule

// File: rtl/tlb_victim_ctl.sv
module tlb_victim_ctl
   import tvc_pkg::*;
#(
   parameter int EPN_W       = 20,
   parameter int SET_W       = 7,
   parameter int WAYS        = 4,
   parameter int FA_ENTRIES  = 16,
   parameter bit RESET_STORE = 1'b1,
   localparam int WAY_W      = $clog2(WAYS),
   localparam int ESEL_W     = $clog2(FA_ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sup_i,
   input  logic              reg_wr_i,
   input  logic [REG_W-1:0]  reg_wdata_i,
   output logic [REG_W-1:0]  reg_rdata_o,
   input  logic [EPN_W-1:0]  epn_i,
   input  logic              wr_entry_i,
   input  logic              rd_entry_i,
   input  logic              srch_i,
   input  logic              srch_hit_i,
   input  logic [WAY_W-1:0]  srch_way_i,
   input  logic              miss_i,
   output logic              arr_sel_o,
   output logic [ESEL_W-1:0] entry_sel_o,
   output logic [SET_W-1:0]  set_idx_o,
   output logic [WAY_W-1:0]  nv_o
);
   if (WAYS != (1 << WAY_W)) begin : g_bad_ways
      $error("WAYS must be a power of two");
   end
   if (FA_ENTRIES != (1 << ESEL_W)) begin : g_bad_fa
      $error("FA_ENTRIES must be a power of two");
   end
   if (ESEL_W < WAY_W) begin : g_bad_esel
      $error("entry-select field narrower than way number");
   end
   if (SET_W > EPN_W) begin : g_bad_set
      $error("set index wider than page number");
   end
   if ((ESEL_LSB + ESEL_W > NV_LSB) || (NV_LSB + WAY_W > REG_W)) begin : g_bad_layout
      $error("register fields overlap or overflow");
   end

   logic              arr_q;
   logic [ESEL_W-1:0] esel_q;
   logic [WAY_W-1:0]  nv_q;
   logic [WAY_W-1:0]  vict;
   logic [SET_W-1:0]  set_idx;
   logic              store_we;

   assign set_idx  = epn_i[SET_W-1:0];
   assign store_we = wr_entry_i && !arr_q;

   tvc_victim_store #(
      .SET_W       (SET_W),
      .NV_W        (WAY_W),
      .RESET_STORE (RESET_STORE)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_set_i (set_idx),
      .wr_en_i  (store_we),
      .wr_set_i (set_idx),
      .wr_val_i (nv_q),
      .rd_val_o (vict)
   );

   tvc_ctl_reg #(
      .ESEL_W (ESEL_W),
      .WAY_W  (WAY_W)
   ) u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .sup_i      (sup_i),
      .sw_wr_i    (reg_wr_i),
      .sw_wdata_i (reg_wdata_i),
      .miss_i     (miss_i),
      .srch_i     (srch_i),
      .srch_hit_i (srch_hit_i),
      .srch_way_i (srch_way_i),
      .rd_entry_i (rd_entry_i),
      .vict_i     (vict),
      .arr_q      (arr_q),
      .esel_q     (esel_q),
      .nv_q       (nv_q),
      .rdata_o    (reg_rdata_o)
   );

   assign arr_sel_o   = arr_q;
   assign entry_sel_o = arr_q ? esel_q : ESEL_W'(esel_q[WAY_W-1:0]);
   assign set_idx_o   = set_idx;
   assign nv_o        = nv_q;

   p_store_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_entry_i && !arr_sel_o) |=> (!$stable(epn_i) || (vict == $past(nv_o))));

   p_fa_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_entry_i && arr_sel_o) |=> (!$stable(epn_i) || $stable(vict)));

   p_fold_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !arr_sel_o |-> (entry_sel_o < ESEL_W'(WAYS)));
endmodule

// File: tb/tb_tlb_victim_ctl.sv
module tb_tlb_victim_ctl;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        sup_i, reg_wr_i, wr_entry_i, rd_entry_i, srch_i, srch_hit_i, miss_i;
   logic [31:0] reg_wdata_i, reg_rdata_o;
   logic [19:0] epn_i;
   logic [1:0]  srch_way_i, nv_o;
   logic        arr_sel_o;
   logic [3:0]  entry_sel_o;
   logic [6:0]  set_idx_o;
   int          total = 0;
   int          bad   = 0;

   always #2.5 clk = ~clk;

   tlb_victim_ctl dut (
      .clk(clk), .rst_n(rst_n), .sup_i(sup_i), .reg_wr_i(reg_wr_i),
      .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .epn_i(epn_i),
      .wr_entry_i(wr_entry_i), .rd_entry_i(rd_entry_i), .srch_i(srch_i),
      .srch_hit_i(srch_hit_i), .srch_way_i(srch_way_i), .miss_i(miss_i),
      .arr_sel_o(arr_sel_o), .entry_sel_o(entry_sel_o), .set_idx_o(set_idx_o),
      .nv_o(nv_o)
   );

   function automatic logic [31:0] mk(input logic a, input logic [3:0] e, input logic [1:0] n);
      return (32'(a)) | (32'(e) << 8) | (32'(n) << 20);
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic idle();
      reg_wr_i = 0; wr_entry_i = 0; rd_entry_i = 0; srch_i = 0;
      srch_hit_i = 0; miss_i = 0; srch_way_i = 0; sup_i = 1;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      idle();
   endtask

   task automatic sw_write(input logic [31:0] d, input logic sup);
      reg_wr_i = 1; reg_wdata_i = d; sup_i = sup;
      step();
   endtask

   task automatic t_reset();
      chk("R1 rdata", reg_rdata_o, 0);
      chk("R1 entry", 32'(entry_sel_o), 0);
      chk("R1 nv", 32'(nv_o), 0);
      epn_i = 20'd3; miss_i = 1; step();
      chk("R1 victim zero after reset", reg_rdata_o, mk(0, 4'd0, 2'd1));
   endtask

   task automatic t_swwrite();
      sw_write(32'hFFFF_FFFF, 1);
      chk("R2 fields and reserved zero", reg_rdata_o, 32'h0030_0F01);
      chk("R4 full entry when array 1", 32'(entry_sel_o), 32'hF);
      sw_write(mk(0, 4'hB, 2'd2), 1);
      chk("R4 folded way when array 0", 32'(entry_sel_o), 32'h3);
      chk("R2 readback raw", reg_rdata_o, mk(0, 4'hB, 2'd2));
      sw_write(32'h0, 0);
      chk("R3 user write ignored", reg_rdata_o, mk(0, 4'hB, 2'd2));
   endtask

   task automatic t_index();
      epn_i = 20'h001A5; #1;
      chk("R5 set index", 32'(set_idx_o), 32'h25);
      epn_i = 20'hFFF80; #1;
      chk("R5 set index high bits", 32'(set_idx_o), 32'h0);
   endtask

   task automatic t_write_entry();
      epn_i = 20'd5;
      wr_entry_i = 1; step();
      sw_write(mk(0, 4'hB, 2'd0), 1);
      rd_entry_i = 1; step();
      chk("R6 R10 read returns stored victim", reg_rdata_o, mk(0, 4'hB, 2'd2));
      miss_i = 1; step();
      chk("R7 miss load", reg_rdata_o, mk(0, 4'd2, 2'd3));
      epn_i = 20'd6; miss_i = 1; step();
      chk("R12 neighbour set untouched", reg_rdata_o, mk(0, 4'd0, 2'd1));
      sw_write(mk(1, 4'd0, 2'd3), 1);
      epn_i = 20'd5; wr_entry_i = 1; step();
      sw_write(mk(0, 4'd0, 2'd0), 1);
      rd_entry_i = 1; step();
      chk("R6 array 1 write leaves pointer", reg_rdata_o, mk(0, 4'd0, 2'd2));
   endtask

   task automatic t_search();
      epn_i = 20'd5; srch_i = 1; srch_hit_i = 0; step();
      chk("R8 search miss", reg_rdata_o, mk(0, 4'd2, 2'd3));
      srch_i = 1; srch_hit_i = 1; srch_way_i = 2'd1; step();
      chk("R9 search hit", reg_rdata_o, mk(0, 4'd1, 2'd2));
   endtask

   task automatic t_wrap();
      sw_write(mk(0, 4'd0, 2'd3), 1);
      epn_i = 20'd7; wr_entry_i = 1; step();
      miss_i = 1; step();
      chk("R7 wrap 3 to 0", reg_rdata_o, mk(0, 4'd3, 2'd0));
   endtask

   task automatic t_priority();
      epn_i = 20'd5; miss_i = 1; srch_i = 1; srch_hit_i = 1; srch_way_i = 2'd1; step();
      chk("R11 miss over search", reg_rdata_o, mk(0, 4'd2, 2'd3));
      epn_i = 20'd7; srch_i = 1; srch_hit_i = 1; srch_way_i = 2'd3; rd_entry_i = 1; step();
      chk("R11 search over read", reg_rdata_o, mk(0, 4'd3, 2'd3));
      epn_i = 20'd5; rd_entry_i = 1; reg_wr_i = 1; reg_wdata_i = 32'hFFFF_FFFF; step();
      chk("R11 read over software write", reg_rdata_o, mk(0, 4'd3, 2'd2));
      chk("R11 array bit kept", 32'(arr_sel_o), 0);
   endtask

   task automatic t_latency();
      epn_i = 20'd6; miss_i = 1; #1;
      chk("R12 no change before edge", reg_rdata_o, mk(0, 4'd3, 2'd2));
      step();
      chk("R12 change after edge", reg_rdata_o, mk(0, 4'd0, 2'd1));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle(); reg_wdata_i = 0; epn_i = 0; rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_swwrite();
      t_index();
      t_write_entry();
      t_search();
      t_wrap();
      t_priority();
      t_latency();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule